// File: doc/BRIEF.md
# Message Activity and Reset Output Select

This block drives one shared active-low status pin for a serial data bus controller. A configuration select bit chooses what the pin shows. With the select at 0 it shows an in-command indicator. That indicator is low while a message is being handled, or, in word monitor mode, while the monitor is online. With the select at 1 it shows a terminal-reset strobe. The strobe pulses low for a fixed number of clock cycles after a reset-terminal mode command arrives in remote terminal mode. In every other mode the pin is held high.

Message decoding and command recognition happen elsewhere. They reach this block as level and strobe inputs. The pin is driven from a register, so it cannot glitch when the select or the mode changes. Without a strobe, the pin reflects the inputs sampled at the previous rising clock edge.

Top module: `msgact_rst_pin`

## Requirements
- R1: While `rst_n` is low, and after its release until the first active condition, `status_pin_no` is 1.
- R2: With `reset_sel_i` = 0 and `mode_i` equal to 0 (bus controller), 1 (remote terminal) or 2 (selective monitor), the pin equals the inverse of `msg_active_i` sampled at the previous rising edge, and `mon_online_i` has no effect.
- R3: With `reset_sel_i` = 0 and `mode_i` = 3 (word monitor), the pin equals the inverse of `mon_online_i` sampled at the previous rising edge, and `msg_active_i` has no effect.
- R4: With `reset_sel_i` = 1 and `mode_i` = 1, a high `rt_reset_cmd_i` sampled at a rising edge drives the pin low for exactly PULSE_CYCLES (default 2) cycles, starting at that edge. The pin then returns high.
- R5: A new `rt_reset_cmd_i` sampled while a pulse is running restarts the full PULSE_CYCLES count from that edge.
- R6: With `reset_sel_i` = 1 and `mode_i` equal to 0, 2 or 3, the pin is 1 whatever `msg_active_i`, `mon_online_i` or `rt_reset_cmd_i` do.
- R7: An `rt_reset_cmd_i` sampled while `mode_i` is not 1 arms no pulse. A switch to mode 1 with select 1 on the next cycle leaves the pin high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 0 bus controller, 1 remote terminal, 2 selective monitor, 3 word monitor |
| msg_active_i | input | 1 | High while a message is being processed |
| mon_online_i | input | 1 | High while the word monitor is online |
| rt_reset_cmd_i | input | 1 | One-cycle strobe: reset-terminal mode command received |
| reset_sel_i | input | 1 | 0 routes the in-command level to the pin, 1 routes the reset strobe |
| status_pin_no | output | 1 | Registered active-low shared status pin |

## Verification
A pulse counter left in the wrong state shows at the pin as a low pulse that is one cycle too short or too long. It can also show as a pulse that never ends, or as no pulse at all. Any of these appears within PULSE_CYCLES cycles of a strobe, or of the later select change to reset mode. A wrong mode decode shows one cycle after the offending input changes: the pin follows the wrong flag, or goes low where it must stay high. The bench compares the pin with a reference model at every clock, so any such fault is reported in the cycle it first appears.

// File: rtl/msgact_pkg.sv
package msgact_pkg;

    typedef enum logic [1:0] {
        MODE_BC   = 2'd0,
        MODE_RT   = 2'd1,
        MODE_SMM  = 2'd2,
        MODE_WMON = 2'd3
    } op_mode_e;

endpackage

// File: rtl/msgact_pulse_timer.sv
module msgact_pulse_timer #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic active_d_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        active_d_o = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LOAD);

    p_rearm_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (st_q.cnt == LOAD));

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/msgact_busy_decode.sv
module msgact_busy_decode
    import msgact_pkg::*;
(
    input  op_mode_e mode_i,
    input  logic     msg_active_i,
    input  logic     mon_online_i,
    output logic     busy_o
);
    always_comb begin
        unique case (mode_i)
            MODE_WMON: busy_o = mon_online_i;
            default:   busy_o = msg_active_i;
        endcase
    end
endmodule

// File: rtl/msgact_rst_pin.sv
module msgact_rst_pin
    import msgact_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       msg_active_i,
    input  logic       mon_online_i,
    input  logic       rt_reset_cmd_i,
    input  logic       reset_sel_i,
    output logic       status_pin_no
);
    typedef struct packed {
        logic pin_n;
    } pin_state_t;

    op_mode_e   mode;
    logic       is_rt;
    logic       busy;
    logic       pulse_on_d;
    pin_state_t st_d, st_q;

    assign mode  = op_mode_e'(mode_i);
    assign is_rt = (mode == MODE_RT);

    msgact_busy_decode i_busy (
        .mode_i       (mode),
        .msg_active_i (msg_active_i),
        .mon_online_i (mon_online_i),
        .busy_o       (busy)
    );

    msgact_pulse_timer #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (rt_reset_cmd_i && is_rt),
        .active_d_o (pulse_on_d)
    );

    always_comb begin
        st_d = st_q;
        if (reset_sel_i) begin
            st_d.pin_n = is_rt ? !pulse_on_d : 1'b1;
        end else begin
            st_d.pin_n = !busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pin_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_pin_no = st_q.pin_n;

    p_msg_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_sel_i && mode_i != 2'd3) |=> (status_pin_no == !$past(msg_active_i)));

    p_online_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_sel_i && mode_i == 2'd3) |=> (status_pin_no == !$past(mon_online_i)));

    p_strobe_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_sel_i && mode_i == 2'd1 && rt_reset_cmd_i) |=> !status_pin_no);

    p_forced_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_sel_i && mode_i != 2'd1) |=> status_pin_no);

endmodule

// File: tb/test_msgact_rst_pin.sv
module test_msgact_rst_pin;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE = 2;
    localparam int WATCHDOG = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       msg = 1'b0;
    logic       onl = 1'b0;
    logic       stb = 1'b0;
    logic       sel = 1'b0;
    logic       pin;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    int    rem = 0;
    logic  exp_pin = 1'b1;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgact_rst_pin #(.PULSE_CYCLES(PULSE)) i_msgact_rst_pin (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode),
        .msg_active_i   (msg),
        .mon_online_i   (onl),
        .rt_reset_cmd_i (stb),
        .reset_sel_i    (sel),
        .status_pin_no  (pin)
    );

    // reference model: pulse remainder as an integer, pin from the rules
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem = 0;
            exp_pin = 1'b1;
        end else begin
            int nxt;
            if (stb && mode == 2'd1) nxt = PULSE;
            else if (rem > 0)        nxt = rem - 1;
            else                     nxt = 0;
            if (sel)                 exp_pin = (mode == 2'd1) ? (nxt == 0) : 1'b1;
            else if (mode == 2'd3)   exp_pin = !onl;
            else                     exp_pin = !msg;
            rem = nxt;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            checks++;
            if (pin !== exp_pin) begin
                errors++;
                $display("FAIL %s: cycle %0d pin=%b expected=%b", cur_req, cycles, pin, exp_pin);
            end
        end
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: pin=%b expected=finish", pin);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input logic [1:0] m, input logic ms, input logic on,
                       input logic s, input logic sl);
        mode = m; msg = ms; onl = on; stb = s; sel = sl;
        @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc(2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        cur_req = "R2";
        for (int m = 0; m < 3; m++) begin
            cyc(2'(m), 1'b1, 1'b0, 1'b0, 1'b0);
            cyc(2'(m), 1'b1, 1'b1, 1'b0, 1'b0);
            cyc(2'(m), 1'b0, 1'b1, 1'b0, 1'b0);
            cyc(2'(m), 1'b0, 1'b0, 1'b0, 1'b0);
        end

        cur_req = "R3";
        cyc(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        cyc(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);

        cur_req = "R4";
        cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) cyc(2'd1, 1'b1, 1'b1, 1'b0, 1'b1);

        cur_req = "R5";
        cyc(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);

        cur_req = "R6";
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            cyc(2'(m), 1'b1, 1'b1, 1'b1, 1'b1);
            cyc(2'(m), 1'b1, 1'b0, 1'b0, 1'b1);
            cyc(2'(m), 1'b0, 1'b1, 1'b1, 1'b1);
        end

        cur_req = "R7";
        cyc(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);

        cur_req = "R1";
        cyc(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        cyc(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        cyc(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule